// File: doc/BRIEF.md
# Pulse-Pause Downlink Frame Encoder

This block is the reader-side transmitter of a pulse-pause coded RFID downlink. A host presents a payload word of up to 31 bits, a keystream word and a bit count, and raises a start request while the block signals it is ready. The block combines payload and keystream with an XOR. It then drives one carrier-enable line: low pauses the field and high keeps the carrier on.

Each bit becomes a symbol. The symbol opens with a fixed pause, and the carrier then stays on for a time that sets the bit value. The symbol length, measured from one pause start to the next, is the only thing that tells a one from a zero. After the last bit a closing pause ends the frame, the carrier comes back on and a one-cycle done pulse is given. All timing counts a tick-enable input that runs at 1.5 ticks per microsecond. A 30-tick pause is therefore 20 us.

Top module: `pulse_pause_tx`

## Requirements
- R1: After reset, carrier_o is 1, ready_o is 1 and done_o is 0.
- R2: Every symbol begins with carrier_o low for exactly 30 ticks, starting in the cycle after the start is accepted.
- R3: A bit of value 1 spans 120 ticks from its pause start to the next pause start (carrier high for 90 ticks). A bit of value 0 spans 60 ticks (carrier high for 30 ticks).
- R4: Exactly nbits_i symbols are sent, bit 0 first, then rising bit positions.
- R5: The value sent is data_i XOR key_i, both latched when the start is accepted. Bits at or above the count are not sent.
- R6: After the last symbol, one closing pause of exactly 30 ticks is sent.
- R7: done_o is high for exactly one cycle after the closing pause ends. carrier_o is high in that cycle and stays high while idle.
- R8: A start is accepted only while ready_o is 1. A start request or a change of data_i, key_i or nbits_i during a frame has no effect on that frame and causes no second done.
- R9: A start with nbits_i equal to 0 or above 31 causes no field activity. done_o is 1 in the cycle after the request.
- R10: Timing advances only on cycles where tick_i is 1. While ticks are withheld, carrier_o holds its level and the frame does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing tick enable, 1.5 per microsecond |
| start_i | input | 1 | Frame start request |
| data_i | input | 31 | Payload, bit 0 sent first |
| key_i | input | 31 | Keystream XORed onto the payload |
| nbits_i | input | 6 | Number of bits to send, valid range 1 to 31 |
| ready_o | output | 1 | Idle, a start is accepted |
| carrier_o | output | 1 | Carrier enable, 0 = field paused |
| done_o | output | 1 | One-cycle pulse at frame end or on rejection |

## Verification
The bench decodes the carrier waveform by run length, counted in ticks, and rebuilds each frame from it. The sweep covers every legal bit count from 1 to 31 with varied payload and keystream pairs, so truncation at each length and the LSB-first order are both exercised. Frames of all ones and all zeros separate the 120-tick and 60-tick symbols in isolation. A frame with a sparse tick rate and a frame where ticks are withheld show that timing follows the tick and not the clock. Counts of 0, 32 and 63 confirm that rejection leaves the field untouched. A start issued mid-frame with different data confirms that the inputs are latched at acceptance.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYM  = 2'd1,
    ST_EOF  = 2'd2,
    ST_DONE = 2'd3
  } ppe_state_e;
endpackage

// File: rtl/ppe_sym_timer.sv
module ppe_sym_timer #(
  parameter int TIMER_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               tick_i,
  output logic [TIMER_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ppe_bit_shift.sv
module ppe_bit_shift #(
  parameter int DATA_W = 31,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              lsb_o,
  output logic              last_o
);
  logic [DATA_W-1:0] keyed;
  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  left_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_key
    assign keyed[i] = data_i[i] ^ key_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sreg_q <= keyed;
      left_q <= nbits_i;
    end else if (shift_i) begin
      sreg_q <= sreg_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign lsb_o  = sreg_q[0];
  assign last_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/pulse_pause_tx.sv
module pulse_pause_tx #(
  parameter int DATA_W  = 31,
  parameter int CNT_W   = 6,
  parameter int T_PAUSE = 30,
  parameter int T_ZERO  = 60,
  parameter int T_ONE   = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              ready_o,
  output logic              carrier_o,
  output logic              done_o
);
  import ppe_pkg::*;

  localparam int TIMER_W = $clog2(T_ONE + 1);
  localparam logic [TIMER_W-1:0] PAUSE_N   = TIMER_W'(T_PAUSE);
  localparam logic [TIMER_W-1:0] PAUSE_END = TIMER_W'(T_PAUSE - 1);
  localparam logic [TIMER_W-1:0] ZERO_END  = TIMER_W'(T_ZERO - 1);
  localparam logic [TIMER_W-1:0] ONE_END   = TIMER_W'(T_ONE - 1);

  ppe_state_e        state_q, state_d;
  logic [TIMER_W-1:0] timer;
  logic              lsb, last;
  logic              len_ok, accept, sym_end, eof_end, timer_clr;
  logic [TIMER_W-1:0] sym_last;

  assign len_ok   = (nbits_i != '0) && (nbits_i <= CNT_W'(DATA_W));
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign sym_last = lsb ? ONE_END : ZERO_END;
  assign sym_end  = (state_q == ST_SYM) && tick_i && (timer == sym_last);
  assign eof_end  = (state_q == ST_EOF) && tick_i && (timer == PAUSE_END);
  assign timer_clr = (state_q == ST_IDLE) || sym_end || eof_end;

  ppe_sym_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (timer_clr),
    .tick_i (tick_i),
    .cnt_o  (timer)
  );

  ppe_bit_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (sym_end),
    .data_i  (data_i),
    .key_i   (key_i),
    .nbits_i (nbits_i),
    .lsb_o   (lsb),
    .last_o  (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = len_ok ? ST_SYM : ST_DONE;
      ST_SYM:  if (sym_end) state_d = last ? ST_EOF : ST_SYM;
      ST_EOF:  if (eof_end) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // field paused during the opening part of a symbol and the whole closing pause
  assign carrier_o = !(((state_q == ST_SYM) || (state_q == ST_EOF)) && (timer < PAUSE_N));
  assign ready_o   = (state_q == ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/ppe_checker.sv
module ppe_checker #(
  parameter int DATA_W  = 31,
  parameter int CNT_W   = 6,
  parameter int T_PAUSE = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             start_i,
  input logic [CNT_W-1:0] nbits_i,
  input logic             ready_o,
  input logic             carrier_o,
  input logic             done_o
);
  localparam int PW = $clog2(T_PAUSE + 2) + 1;
  logic [PW-1:0] low_ticks;
  logic          bad_len;

  assign bad_len = (nbits_i == '0) || (nbits_i > CNT_W'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        low_ticks <= '0;
    else if (carrier_o) low_ticks <= '0;
    else if (tick_i)    low_ticks <= low_ticks + 1'b1;
  end

  AST_IDLE_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> carrier_o); // R1
  AST_PAUSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_ticks <= PW'(T_PAUSE)); // R2
  AST_ACCEPT_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && !bad_len) |=> (!carrier_o && !ready_o)); // R2
  AST_DONE_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> carrier_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> !ready_o || $past(done_o)); // R8
  AST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && bad_len) |=> (done_o && carrier_o)); // R9
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ready_o && !done_o) |=> ($stable(carrier_o) && !done_o)); // R10
endmodule

bind pulse_pause_tx ppe_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .T_PAUSE(T_PAUSE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .start_i   (start_i),
  .nbits_i   (nbits_i),
  .ready_o   (ready_o),
  .carrier_o (carrier_o),
  .done_o    (done_o)
);

// File: tb/pulse_pause_tx_tb_top.sv
module pulse_pause_tx_tb_top;
  localparam int DW = 31;
  localparam int CW = 6;
  localparam int TP = 30;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] key_i = '0;
  logic [CW-1:0] nbits_i = '0;
  logic          ready_o, carrier_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  pulse_pause_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .data_i(data_i), .key_i(key_i), .nbits_i(nbits_i),
    .ready_o(ready_o), .carrier_o(carrier_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Send one frame and decode carrier_o by run length counted in ticks.
  // div: tick every div cycles; hold: withhold ticks for a window; poke: mid-frame start.
  task automatic run_frame(input logic [DW-1:0] d, input logic [DW-1:0] k, input int n,
                           input int div, input bit hold, input bit poke);
    logic [DW-1:0] expw, got;
    int lows, highs, run, it, pause_bad, high_bad, dones;
    bit lvl, held_lvl, hold_ok;
    expw = (d ^ k) & DW'((32'h1 << n) - 1);
    got = '0; lows = 0; highs = 0; run = 0; pause_bad = 0; high_bad = 0; dones = 0;
    hold_ok = 1'b1; held_lvl = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; data_i = d; key_i = k; nbits_i = CW'(n); tick_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(carrier_o == 1'b0, "R2 pause at accept", carrier_o, 0);
    lvl = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      it = i;
      if (carrier_o != lvl) begin
        if (lvl == 1'b0) begin
          if (run != TP) pause_bad++;
          lows++;
        end else begin
          if (run == 90) got[highs] = 1'b1;
          else if (run != 30) high_bad++;
          highs++;
        end
        run = 0;
        lvl = carrier_o;
      end
      if (done_o) begin
        dones++;
        chk(carrier_o == 1'b1, "R7 carrier high at done", carrier_o, 1);
        break;
      end
      if (poke && i == 40) begin
        start_i = 1'b1; data_i = ~d; key_i = '0; nbits_i = CW'(3);
      end else begin
        start_i = 1'b0;
      end
      if (hold && i == 100) held_lvl = carrier_o;
      if (hold && i > 100 && i < 200 && carrier_o != held_lvl) hold_ok = 1'b0;
      tick_i = !(hold && i >= 100 && i < 199) && ((i % div) == 0);
      if (tick_i) run++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    tick_i = 1'b0;
    chk(dones == 1, "R7 done seen", dones, 1);
    chk(pause_bad == 0, "R2 pause length", pause_bad, 0);
    chk(high_bad == 0, "R3 carrier-on length", high_bad, 0);
    chk(lows == n + 1, "R4/R6 pause count", lows, n + 1);
    chk(highs == n, "R4 symbol count", highs, n);
    chk(got == expw, "R5 decoded word", got, expw);
    if (hold) chk(hold_ok, "R10 carrier held without tick", hold_ok, 1);
    @(negedge clk_i);
    chk(!done_o && ready_o && carrier_o, "R7 single done pulse, idle", done_o, 0);
    if (poke) begin
      dones = 0;
      for (int j = 0; j < 10; j++) begin
        if (done_o || !carrier_o) dones++;
        @(negedge clk_i);
      end
      chk(dones == 0, "R8 mid-frame start ignored", dones, 0);
    end
  endtask

  task automatic reject(input int n);
    @(negedge clk_i);
    start_i = 1'b1; nbits_i = CW'(n); data_i = '1; tick_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o && carrier_o, "R9 reject done next cycle", done_o, 1);
    @(negedge clk_i);
    chk(!done_o && ready_o && carrier_o, "R9 no field activity", carrier_o, 1);
    tick_i = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!finished) begin
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(carrier_o && ready_o && !done_o, "R1 reset state", {carrier_o, ready_o, done_o}, 6);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(carrier_o && ready_o && !done_o, "R1 after reset release", {carrier_o, ready_o, done_o}, 6);
    for (int n = 1; n <= DW; n++)
      run_frame(DW'(32'h5A3C96E1 * n), DW'(32'h01234567 * (n + 3)), n, 1, 1'b0, 1'b0);
    run_frame('1, '0, 31, 1, 1'b0, 1'b0);             // R3 all ones
    run_frame('0, '0, 31, 1, 1'b0, 1'b0);             // R3 all zeros
    run_frame(DW'(32'h2AAAAAAA), '1, 31, 1, 1'b0, 1'b0); // R5 key inverts
    run_frame(DW'(32'h0000BEEF), DW'(32'h00001111), 16, 3, 1'b0, 1'b0); // R10 sparse ticks
    run_frame(DW'(32'h00000055), '0, 8, 1, 1'b1, 1'b0); // R10 ticks withheld
    run_frame(DW'(32'h0000003C), DW'(32'h5), 10, 1, 1'b0, 1'b1); // R8 busy start
    reject(0);
    reject(32);
    reject(63);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule